// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Clear-on-Read Status

The block turns an asynchronous serial line into characters. The line is oversampled by a clock-enable tick that runs at sixteen times the bit rate. Each frame is one low start bit, then 7, 8 or 9 data bits sent LSB first. An optional parity bit follows the data, and the frame closes with one stop bit. Every completed character goes into a single receive buffer, and a full flag tells the host that the buffer holds a character. The host empties the buffer with a one-cycle read strobe.

Line faults are recorded as sticky flags: overrun, parity, framing and break. The host clears all of them with one status-read strobe. A global error output is the OR of the four flags. A receiving-error indicator shows that a frame ended with its stop bit low; it stays high until the line returns high. An attention mode serves multi-drop address filtering. While it is active, only characters whose ninth bit is set are accepted, and the first such character ends the mode. The receive interrupt is the full flag gated by an enable input.

Top module: `uart_rx_status`

## Requirements
- R1: `len_cfg_i` selects the number of data bits. 2'b00 selects 8, 2'b01 selects 7 and 2'b10 selects 9. 2'b11 selects 9 and takes the serial input from `loop_i` instead of `rx_i`.
- R2: Each bit lasts 16 ticks. Its value is the majority of samples 7, 8 and 9 of that bit. A low line in idle begins a start bit, and the attempt is dropped if the start bit's vote is high. A single-cycle glitch inside a bit does not change that bit.
- R3: A completed character sets `rx_full_o`. Its low 8 data bits go to `rbuf_o`, zero-extended, and its ninth bit goes to `rbit9_o`, which is 0 in 7- and 8-bit modes. Characters with errors are loaded too. A pulse on `rbuf_rd_i` clears `rx_full_o`.
- R4: If an accepted character completes while `rx_full_o` is set and no buffer read happens in that cycle, `ovr_o` is set and the buffer keeps its earlier character.
- R5: When `par_en_i` is 1, a parity bit follows the data bits. Parity is even when `par_odd_i` is 0 and odd when it is 1. A mismatch sets `par_o`.
- R6: `brk_o` is set when the start bit, every data bit, the parity bit (if enabled) and the stop bit are all sampled low. `frm_o` is set when the stop bit is low and the frame is not a break.
- R7: `ovr_o`, `par_o`, `frm_o` and `brk_o` stay set until a `stat_rd_i` pulse clears them in the next cycle. A flag raised in the same cycle as the strobe stays set. `stat_rd_i` does not affect `rx_full_o`.
- R8: `err_o` is high exactly when at least one of `ovr_o`, `par_o`, `frm_o` or `brk_o` is high.
- R9: A pulse on `attn_set_i` sets `attn_o`. While `attn_o` is high, characters whose ninth bit is 0 are discarded without setting `rx_full_o`. A character whose ninth bit is 1 is accepted and clears `attn_o`.
- R10: `rcv_err_o` rises when a frame ends with a framing error or a break. It falls once the synchronized line is high.
- R11: `irq_o` equals `rx_full_o` AND `rx_irq_en_i`.
- R12: After reset, all flags, `attn_o`, `rcv_err_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, 16 per bit |
| rx_i | input | 1 | Serial line |
| loop_i | input | 1 | Loopback serial input, used when len_cfg_i is 2'b11 |
| len_cfg_i | input | 2 | Data-length code |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity select |
| rbuf_rd_i | input | 1 | Host buffer read strobe |
| stat_rd_i | input | 1 | Host status read strobe |
| attn_set_i | input | 1 | Enter attention mode |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| rbuf_o | output | 8 | Receive buffer |
| rbit9_o | output | 1 | Ninth received bit |
| rx_full_o | output | 1 | Buffer holds a character |
| ovr_o | output | 1 | Overrun flag |
| frm_o | output | 1 | Framing error flag |
| par_o | output | 1 | Parity error flag |
| brk_o | output | 1 | Break flag |
| err_o | output | 1 | Any error flag set |
| attn_o | output | 1 | Attention mode active |
| rcv_err_o | output | 1 | Stop-low frame seen, line not yet high |
| irq_o | output | 1 | Receive interrupt |

## Verification
Frame results pass through two synchronizer stages, are voted at sample 9 of the stop bit, and are then registered twice. They settle about 13 ticks into the stop bit. The bench checks them 22 cycles after the stop bit begins, once the line has been idle for six cycles. Buffer and flag clears are due one edge after the read strobe, and the bench checks them on the falling edge that ends the strobe. `rcv_err_o` falls about three cycles after the line goes high, so it is checked six cycles later. The bench drives stimulus and samples outputs only on falling edges.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MAX_BITS = 9;
  localparam int BUF_W    = 8;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                par_err;
    logic                frm_err;
    logic                brk;
  } rx_frame_t;

  function automatic logic [3:0] data_bits(input logic [1:0] cfg);
    case (cfg)
      2'b00:   data_bits = 4'd8;
      2'b01:   data_bits = 4'd7;
      default: data_bits = 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[i] <= 1'b1;
        else         ff_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[i] <= 1'b1;
        else         ff_q[i] <= ff_q[i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      line_i,
  input  logic [1:0] len_cfg_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  output logic      done_o,
  output rx_frame_t frame_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] SMP_A = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] SMP_B = CNT_W'(OVS/2);
  localparam logic [CNT_W-1:0] SMP_C = CNT_W'(OVS/2 + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(OVS - 1);

  rx_state_e           state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [1:0]          samp_q;
  logic [3:0]          idx_q;
  logic [MAX_BITS-1:0] shreg_q;
  logic                par_acc_q, par_bit_q, all_low_q;

  logic       vote, at_vote, at_end;
  logic [3:0] nbits;

  assign vote    = (samp_q[1] & samp_q[0]) | (samp_q[1] & line_i) | (samp_q[0] & line_i);
  assign at_vote = tick_i && (cnt_q == SMP_C);
  assign at_end  = tick_i && (cnt_q == LAST);
  assign nbits   = data_bits(len_cfg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      samp_q    <= '1;
      idx_q     <= '0;
      shreg_q   <= '0;
      par_acc_q <= 1'b0;
      par_bit_q <= 1'b0;
      all_low_q <= 1'b0;
      done_o    <= 1'b0;
      frame_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick_i && state_q != RX_IDLE && state_q != RX_HOLD) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == SMP_A || cnt_q == SMP_B) samp_q <= {samp_q[0], line_i};
      end
      case (state_q)
        RX_IDLE: if (tick_i && !line_i) begin
          state_q   <= RX_START;
          cnt_q     <= CNT_W'(1);
          idx_q     <= '0;
          shreg_q   <= '0;
          par_acc_q <= 1'b0;
          all_low_q <= 1'b1;
        end
        RX_START: begin
          if (at_vote && vote) state_q <= RX_IDLE;  // false start
          else if (at_end)     state_q <= RX_DATA;
        end
        RX_DATA: begin
          if (at_vote) begin
            shreg_q   <= {vote, shreg_q[MAX_BITS-1:1]};
            par_acc_q <= par_acc_q ^ vote;
            all_low_q <= all_low_q & ~vote;
          end
          if (at_end) begin
            if (idx_q == nbits - 4'd1) begin
              idx_q   <= '0;
              state_q <= par_en_i ? RX_PAR : RX_STOP;
            end else begin
              idx_q <= idx_q + 4'd1;
            end
          end
        end
        RX_PAR: begin
          if (at_vote) begin
            par_bit_q <= vote;
            all_low_q <= all_low_q & ~vote;
          end
          if (at_end) state_q <= RX_STOP;
        end
        RX_STOP: if (at_vote) begin
          done_o          <= 1'b1;
          frame_o.data    <= shreg_q >> (MAX_BITS - int'(nbits));
          frame_o.par_err <= par_en_i & (par_acc_q ^ par_bit_q ^ par_odd_i);
          frame_o.brk     <= all_low_q & ~vote;
          frame_o.frm_err <= ~all_low_q & ~vote;
          state_q         <= vote ? RX_IDLE : RX_HOLD;
        end
        RX_HOLD: if (line_i) state_q <= RX_IDLE;  // rearm only after line returns high
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_status_regs.sv
module uart_rx_status_regs
  import uart_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  rx_frame_t        frame_i,
  input  logic             line_i,
  input  logic             rbuf_rd_i,
  input  logic             stat_rd_i,
  input  logic             attn_set_i,
  output logic [BUF_W-1:0] rbuf_o,
  output logic             rbit9_o,
  output logic             full_o,
  output logic             ovr_o,
  output logic             frm_o,
  output logic             par_o,
  output logic             brk_o,
  output logic             attn_o,
  output logic             rcv_err_o
);
  logic nine, accept, busy;

  assign nine   = frame_i.data[MAX_BITS-1];
  assign accept = done_i && (!attn_o || nine);
  assign busy   = full_o && !rbuf_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_o    <= '0;
      rbit9_o   <= 1'b0;
      full_o    <= 1'b0;
      ovr_o     <= 1'b0;
      frm_o     <= 1'b0;
      par_o     <= 1'b0;
      brk_o     <= 1'b0;
      attn_o    <= 1'b0;
      rcv_err_o <= 1'b0;
    end else begin
      if (accept && !busy) begin
        rbuf_o  <= frame_i.data[BUF_W-1:0];
        rbit9_o <= nine;
        full_o  <= 1'b1;
      end else if (rbuf_rd_i) begin
        full_o <= 1'b0;
      end
      // set wins over clear-on-read
      ovr_o <= (accept & busy)                  | (ovr_o & ~stat_rd_i);
      frm_o <= (done_i & frame_i.frm_err)       | (frm_o & ~stat_rd_i);
      par_o <= (done_i & frame_i.par_err)       | (par_o & ~stat_rd_i);
      brk_o <= (done_i & frame_i.brk)           | (brk_o & ~stat_rd_i);

      if (attn_set_i)          attn_o <= 1'b1;
      else if (done_i && nine) attn_o <= 1'b0;

      if (done_i && (frame_i.frm_err || frame_i.brk)) rcv_err_o <= 1'b1;
      else if (line_i)                                rcv_err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rx_i,
  input  logic             loop_i,
  input  logic [1:0]       len_cfg_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             rbuf_rd_i,
  input  logic             stat_rd_i,
  input  logic             attn_set_i,
  input  logic             rx_irq_en_i,
  output logic [BUF_W-1:0] rbuf_o,
  output logic             rbit9_o,
  output logic             rx_full_o,
  output logic             ovr_o,
  output logic             frm_o,
  output logic             par_o,
  output logic             brk_o,
  output logic             err_o,
  output logic             attn_o,
  output logic             rcv_err_o,
  output logic             irq_o
);
  logic      line_raw, line_s, frame_done;
  rx_frame_t frame_q;

  assign line_raw = (len_cfg_i == 2'b11) ? loop_i : rx_i;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_raw),
    .q_o   (line_s)
  );

  uart_rx_deframer #(.OVS(OVS)) u_deframer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .line_i   (line_s),
    .len_cfg_i(len_cfg_i),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .done_o   (frame_done),
    .frame_o  (frame_q)
  );

  uart_rx_status_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (frame_done),
    .frame_i   (frame_q),
    .line_i    (line_s),
    .rbuf_rd_i (rbuf_rd_i),
    .stat_rd_i (stat_rd_i),
    .attn_set_i(attn_set_i),
    .rbuf_o    (rbuf_o),
    .rbit9_o   (rbit9_o),
    .full_o    (rx_full_o),
    .ovr_o     (ovr_o),
    .frm_o     (frm_o),
    .par_o     (par_o),
    .brk_o     (brk_o),
    .attn_o    (attn_o),
    .rcv_err_o (rcv_err_o)
  );

  assign err_o = ovr_o | frm_o | par_o | brk_o;
  assign irq_o = rx_full_o & rx_irq_en_i;
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic stat_rd_i,
  input logic rbuf_rd_i,
  input logic rx_full_o,
  input logic ovr_o,
  input logic frm_o,
  input logic par_o,
  input logic brk_o,
  input logic attn_o,
  input logic rcv_err_o,
  input logic done_i,
  input logic nine_i,
  input logic line_i
);
  assert_full_needs_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> $past(done_i));
  assert_full_clears_on_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_full_o) |-> $past(rbuf_rd_i));
  assert_ovr_needs_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(rx_full_o));
  assert_brk_needs_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_o) |-> $past(done_i));
  assert_ovr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovr_o) |-> $past(stat_rd_i));
  assert_frm_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frm_o) |-> $past(stat_rd_i));
  assert_par_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(par_o) |-> $past(stat_rd_i));
  assert_brk_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brk_o) |-> $past(stat_rd_i));
  assert_attn_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(attn_o) |-> $past(done_i && nine_i));
  assert_rcv_err_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rcv_err_o) |-> $past(line_i));
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stat_rd_i(stat_rd_i),
  .rbuf_rd_i(rbuf_rd_i),
  .rx_full_o(rx_full_o),
  .ovr_o    (ovr_o),
  .frm_o    (frm_o),
  .par_o    (par_o),
  .brk_o    (brk_o),
  .attn_o   (attn_o),
  .rcv_err_o(rcv_err_o),
  .done_i   (frame_done),
  .nine_i   (frame_q.data[8]),
  .line_i   (line_s)
);

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, loopb = 1'b1;
  logic [1:0] cfg = 2'b00;
  logic par_en = 1'b0, par_odd = 1'b0;
  logic rbuf_rd = 1'b0, stat_rd = 1'b0, attn_set = 1'b0, irq_en = 1'b0;
  logic [7:0] rbuf;
  logic rbit9, full, ovr, frm, par, brk, err, attn, rcv_err, irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  uart_rx_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .rx_i(rx), .loop_i(loopb),
    .len_cfg_i(cfg), .par_en_i(par_en), .par_odd_i(par_odd),
    .rbuf_rd_i(rbuf_rd), .stat_rd_i(stat_rd), .attn_set_i(attn_set),
    .rx_irq_en_i(irq_en), .rbuf_o(rbuf), .rbit9_o(rbit9), .rx_full_o(full),
    .ovr_o(ovr), .frm_o(frm), .par_o(par), .brk_o(brk), .err_o(err),
    .attn_o(attn), .rcv_err_o(rcv_err), .irq_o(irq)
  );

  // {cfg[1:0], par_en, par_odd, bad_par, stop, irq_en, data[8:0]}
  localparam logic [15:0] VEC [9] = '{
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0A5},
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'h05A},
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'h1C3},
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'h13C},
    {2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0F1},
    {2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'h033},
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h081},
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h000},
    {2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 9'h07F}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] c);
    return (c == 2'b00) ? 8 : (c == 2'b01) ? 7 : 9;
  endfunction

  task automatic put(input logic b, input logic glitch);
    if (cfg == 2'b11) loopb = b; else rx = b;
    for (int c = 0; c < 16; c++) begin
      if (glitch && c == 8) begin
        if (cfg == 2'b11) loopb = ~b; else rx = ~b;
      end else if (glitch && c == 9) begin
        if (cfg == 2'b11) loopb = b; else rx = b;
      end
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [8:0] d, input logic bad_par, input logic stop,
                      input logic glitch, input logic keep_low);
    logic p;
    p = par_odd ^ bad_par;
    put(1'b0, 1'b0);
    for (int i = 0; i < nb(cfg); i++) begin
      put(d[i], glitch);
      p ^= d[i];
    end
    if (par_en) put(p, 1'b0);
    put(stop, 1'b0);
    if (!keep_low) begin
      rx = 1'b1; loopb = 1'b1;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic strobe(input logic buf_rd, input logic st_rd);
    rbuf_rd = buf_rd; stat_rd = st_rd;
    @(negedge clk);
    rbuf_rd = 1'b0; stat_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 full", full, 0);
    chk("R12 err", err, 0);
    chk("R12 attn", attn, 0);
    chk("R12 rcv_err", rcv_err, 0);
    chk("R12 irq", irq, 0);

    // table walk: R1 R3 R5 R6 R8 R11
    for (int v = 0; v < 9; v++) begin
      logic [8:0] m, d;
      logic pb, e_par, e_brk, e_frm, stp, bad;
      cfg = VEC[v][15:14]; par_en = VEC[v][13]; par_odd = VEC[v][12];
      bad = VEC[v][11]; stp = VEC[v][10]; irq_en = VEC[v][9]; d = VEC[v][8:0];
      m = d & 9'((1 << nb(cfg)) - 1);
      pb = (^m) ^ par_odd ^ bad;
      e_par = par_en & bad;
      e_brk = !stp && m == 0 && (!par_en || !pb);
      e_frm = !stp && !e_brk;
      send(d, bad, stp, 1'b0, 1'b0);
      chk("R3 full", full, 1);
      chk("R1 R3 rbuf", rbuf, m[7:0]);
      chk("R1 R3 rbit9", rbit9, m[8]);
      chk("R5 par", par, e_par);
      chk("R6 frm", frm, e_frm);
      chk("R6 brk", brk, e_brk);
      chk("R8 err", err, e_par | e_frm | e_brk);
      chk("R11 irq", irq, irq_en);
      strobe(1'b1, 1'b1);
      chk("R3 full cleared", full, 0);
      chk("R7 err cleared", err, 0);
      chk("R11 irq cleared", irq, 0);
    end

    // R4 overrun keeps first character; R7 status read leaves full alone
    cfg = 2'b00; par_en = 1'b0; par_odd = 1'b0;
    send(9'h011, 1'b0, 1'b1, 1'b0, 1'b0);
    send(9'h022, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 ovr", ovr, 1);
    chk("R4 rbuf kept", rbuf, 8'h11);
    chk("R8 err on ovr", err, 1);
    strobe(1'b0, 1'b1);
    chk("R7 ovr cleared", ovr, 0);
    chk("R7 full kept", full, 1);
    strobe(1'b1, 1'b0);

    // R7 flag survives a later clean frame
    send(9'h0C0, 1'b0, 1'b0, 1'b0, 1'b0);
    strobe(1'b1, 1'b0);
    send(9'h044, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 frm sticky", frm, 1);
    chk("R7 rbuf new", rbuf, 8'h44);
    strobe(1'b1, 1'b1);
    chk("R7 frm cleared", frm, 0);

    // R2 false start then glitched bits
    rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 false start", full, 0);
    send(9'h0FF, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R2 glitch vote", rbuf, 8'hFF);
    strobe(1'b1, 1'b1);

    // R9 attention filtering
    cfg = 2'b10;
    attn_set = 1'b1; @(negedge clk); attn_set = 1'b0;
    chk("R9 attn set", attn, 1);
    send(9'h0AB, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 discarded", full, 0);
    chk("R9 attn held", attn, 1);
    send(9'h1CD, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 accepted", full, 1);
    chk("R9 rbuf", rbuf, 8'hCD);
    chk("R9 attn exit", attn, 0);
    strobe(1'b1, 1'b1);

    // R10 receiving-error indicator over a held break
    cfg = 2'b00;
    send(9'h000, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (30) @(negedge clk);
    chk("R10 rcv_err high", rcv_err, 1);
    chk("R6 brk held line", brk, 1);
    rx = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 rcv_err drop", rcv_err, 0);
    chk("R7 brk still set", brk, 1);
    strobe(1'b1, 1'b1);

    finished = 1;
    summary();
    $finish;
  end
endmodule